// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number by fetching one entry from a flat page table in memory. A requester hands it a virtual page number together with a flag that says whether the access is a load or a store. The walker computes the entry address from a base register, reads the entry over a simple memory port and inspects it. It then returns either the physical page number with the entry's status bits, or a page-fault indication. Pages are 4 KiB, so the low 12 address bits are the page offset and are never presented to the walker.

The walker keeps the usage bits in memory up to date on its own. It sets the referenced bit on every access to a present page and the modified bit on every store. It writes the entry back only when one of those bits actually changes. The table base can only be loaded while the privileged-mode input is high. Only one walk is handled at a time, and only one memory transaction is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_o` are 0.
- R2: The entry is read from address base + VPN*4, using the base value that held when the request was accepted.
- R3: An entry is 32 bits wide. Bit 0 is present, bit 1 is referenced, bit 2 is modified, and bits 31:12 hold the physical page number. For a present entry the response has `rsp_fault_o`=0 and `rsp_ppn_o` = entry[31:12].
- R4: For an entry whose bit 0 is 0, the response has `rsp_fault_o`=1, `rsp_ppn_o`=0, `rsp_ref_o`=0 and `rsp_dirty_o`=0, and no memory write is issued.
- R5: Every walk that hits a present entry leaves bit 1 set in memory, and the response reports `rsp_ref_o`=1.
- R6: A walk with `req_write_i`=1 on a present entry leaves bit 2 set in memory and reports `rsp_dirty_o`=1. A load walk leaves bit 2 unchanged.
- R7: A write-back happens exactly when the updated entry differs from the one read. It writes the updated entry to the same address.
- R8: `base_wdata_i` is loaded into the base register on a cycle with `base_we_i`=1 only if `priv_i`=1. Without `priv_i` the base is left unchanged.
- R9: `req_ready_o` is 0 from the cycle after acceptance until the response. `rsp_valid_o` is a one-cycle pulse, one per accepted request.
- R10: `mem_req_o` stays high with a stable address, write flag and data until the cycle in which `mem_rvalid_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Privileged mode; enables base loads |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | New table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vpn_i | input | 20 | Virtual page number to translate |
| req_write_i | input | 1 | Request is a store access |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Entry not present |
| rsp_ppn_o | output | 20 | Physical page number |
| rsp_ref_o | output | 1 | Referenced bit after update |
| rsp_dirty_o | output | 1 | Modified bit after update |
| mem_req_o | output | 1 | Memory transaction request, held until acknowledged |
| mem_we_o | output | 1 | Transaction is a write |
| mem_addr_o | output | 32 | Entry byte address |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_rvalid_i | input | 1 | One-cycle completion strobe for read or write |
| mem_rdata_i | input | 32 | Read data, valid with the strobe |

## Verification
The assertions rely on the memory side raising `mem_rvalid_i` only while a transaction is pending. They also rely on the base register being rewritten only while the walker is idle. The bench memory model answers each transaction after a fixed latency, with a single strobe, and never strobes on its own. Base writes are issued only between walks. With these inputs held in that range, the checks cover handshake stability, the single-pulse response, the fault response and the privilege gate on the base register.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VPN_W  = 20,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv_i,
  input  logic               base_we_i,
  input  logic [ADDR_W-1:0]  base_wdata_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [PTE_W-OFF_W-1:0] rsp_ppn_o,
  output logic               rsp_ref_o,
  output logic               rsp_dirty_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0]   mem_wdata_o,
  input  logic               mem_rvalid_i,
  input  logic [PTE_W-1:0]   mem_rdata_i
);
  localparam int PPN_W = PTE_W - OFF_W;
  localparam int SHIFT = $clog2(PTE_W / 8);
  localparam int B_VLD = 0;
  localparam int B_REF = 1;
  localparam int B_DRT = 2;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_WB, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [PTE_W-1:0]  pte_q, pte_upd;
  logic              wr_q, fault_q;

  always_comb begin
    pte_upd = pte_q;
    pte_upd[B_REF] = 1'b1;
    if (wr_q) pte_upd[B_DRT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_we_i && priv_i) base_q <= base_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      pte_q   <= '0;
      wr_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid_i) begin
          addr_q <= base_q + (ADDR_W'(req_vpn_i) << SHIFT);
          wr_q   <= req_write_i;
          state  <= S_READ;
        end
        S_READ: if (mem_rvalid_i) begin
          pte_q <= mem_rdata_i;
          state <= S_CHECK;
        end
        S_CHECK: begin
          fault_q <= !pte_q[B_VLD];
          if (!pte_q[B_VLD]) state <= S_DONE;
          else begin
            pte_q <= pte_upd;
            state <= (pte_upd != pte_q) ? S_WB : S_DONE;
          end
        end
        S_WB:   if (mem_rvalid_i) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state == S_IDLE);
  assign mem_req_o   = (state == S_READ) || (state == S_WB);
  assign mem_we_o    = (state == S_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pte_q;
  assign rsp_valid_o = (state == S_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_ppn_o   = fault_q ? '0 : pte_q[PTE_W-1:OFF_W];
  assign rsp_ref_o   = !fault_q && pte_q[B_REF];
  assign rsp_dirty_o = !fault_q && pte_q[B_DRT];

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_busy_on_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_fault_o |-> rsp_ppn_o == '0 && !rsp_ref_o && !rsp_dirty_o);

  p_hit_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fault_o |-> rsp_ref_o);

  p_store_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fault_o && wr_q |-> rsp_dirty_o);

  p_base_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    base_q != $past(base_q) |-> $past(base_we_i && priv_i));

  p_wb_sets_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_wdata_o[B_REF] && mem_wdata_o[B_VLD]);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_i = 1'b0, base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [19:0] req_vpn_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_fault_o, rsp_ref_o, rsp_dirty_o;
  logic [19:0] rsp_ppn_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .base_we_i(base_we_i),
    .base_wdata_i(base_wdata_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vpn_i(req_vpn_i), .req_write_i(req_write_i), .rsp_valid_o(rsp_valid_o),
    .rsp_fault_o(rsp_fault_o), .rsp_ppn_o(rsp_ppn_o), .rsp_ref_o(rsp_ref_o),
    .rsp_dirty_o(rsp_dirty_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i));

  int          n_chk = 0, n_bad = 0;
  logic [31:0] mem [256];
  logic [31:0] rd_addr = '0, wr_addr = '0;
  int          wr_cnt = 0, rsp_cnt = 0;
  logic        busy = 1'b0;
  int          lat = 0;
  logic [22:0] expq [$];
  logic [31:0] base_model = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (mem_req_o && !mem_rvalid_i && !busy) begin
      busy <= 1'b1;
      lat  <= 2;
    end else if (busy) begin
      if (lat == 0) begin
        busy <= 1'b0;
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[mem_addr_o[9:2]];
        if (mem_we_o) begin
          mem[mem_addr_o[9:2]] <= mem_wdata_o;
          wr_cnt  <= wr_cnt + 1;
          wr_addr <= mem_addr_o;
        end else rd_addr <= mem_addr_o;
      end else lat <= lat - 1;
    end
  end

  always @(negedge clk) begin
    if (rsp_valid_o) begin
      logic [22:0] e;
      if (expq.size() == 0) check("R9 unexpected response", 32'(rsp_valid_o), 32'd0);
      else begin
        e = expq.pop_front();
        check("R3/R4 fault", 32'(rsp_fault_o), 32'(e[22]));
        check("R3/R4 ppn", 32'(rsp_ppn_o), 32'(e[21:2]));
        check("R5 ref", 32'(rsp_ref_o), 32'(e[1]));
        check("R6 dirty", 32'(rsp_dirty_o), 32'(e[0]));
      end
      rsp_cnt++;
    end
  end

  task automatic set_base(input logic [31:0] b, input logic p);
    @(negedge clk);
    base_we_i = 1'b1; priv_i = p; base_wdata_i = b;
    @(negedge clk);
    base_we_i = 1'b0; priv_i = 1'b0;
    if (p) base_model = b;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic wr);
    logic [31:0] ea, pte, upd;
    int          w0, r0;
    ea  = base_model + {vpn, 2'b00};
    pte = mem[ea[9:2]];
    upd = pte | 32'h2 | (wr ? 32'h4 : 32'h0);
    if (!pte[0]) begin expq.push_back({1'b1, 20'd0, 2'b00}); upd = pte; end
    else expq.push_back({1'b0, upd[31:12], upd[1], upd[2]});
    w0 = wr_cnt; r0 = rsp_cnt;
    @(negedge clk);
    req_valid_i = 1'b1; req_vpn_i = vpn; req_write_i = wr;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R9 ready low while busy", 32'(req_ready_o), 32'd0);
    while (rsp_cnt == r0) @(negedge clk);
    check("R2 entry address", rd_addr, ea);
    check("R7 write-back count", 32'(wr_cnt - w0), (upd != pte) ? 32'd1 : 32'd0);
    if (upd != pte) check("R7 write-back address", wr_addr, ea);
    check("R5/R6 entry in memory", mem[ea[9:2]], upd);
    @(negedge clk);
    check("R9 ready again", 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[64 + 3]  = 32'hABCDE001;
    mem[64 + 5]  = 32'h12345000;
    mem[64 + 7]  = 32'hFFFFF007;
    mem[128 + 60] = 32'h00042003;
    repeat (3) @(negedge clk);
    check("R1 ready", 32'(req_ready_o), 32'd1);
    check("R1 rsp", 32'(rsp_valid_o), 32'd0);
    check("R1 mem_req", 32'(mem_req_o), 32'd0);
    rst_n = 1'b1;
    set_base(32'h100, 1'b1);
    walk(20'd3, 1'b0);
    walk(20'd3, 1'b0);
    walk(20'd3, 1'b1);
    walk(20'd3, 1'b1);
    walk(20'd5, 1'b0);
    walk(20'd7, 1'b1);
    set_base(32'h200, 1'b0);
    walk(20'd3, 1'b0);
    set_base(32'h200, 1'b1);
    walk(20'd60, 1'b1);
    walk(20'd61, 1'b1);
    check("R9 all responses", 32'(expq.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule